// File: doc/BRIEF.md
# Baud Rate Generator Channel

One channel of a programmable bit-rate source. A reference tick input, normally the system clock pre-divided so that serial receivers see a 16x oversampling rate, is divided by a host-programmed ratio. The result is a one-cycle clock-enable pulse per output period plus a square wave that flips on every pulse. A 12-bit reloadable down-counter sets the ratio. An optional fixed divide-by-16 prescaler ahead of it covers rates whose divisor would not fit in 12 bits.

The host writes a single configuration word. The divisor field holds the wanted ratio minus one, stored one bit up from the word's least significant bit. Bit 0 selects the prescaler and bit 16 starts the channel. While the channel is stopped the counter waits at the divisor, so each start begins a full period. Routing channels to serial controllers happens outside this block.

Top module: `baud_gen`

## Requirements
- R1: After reset the pulse and square-wave outputs are 0 and the configuration reads back as 0.
- R2: The configuration word is 17 bits: bit 16 enables, bits 12:1 hold the divisor D, bit 0 selects the prescaler; bits 15:13 read as 0. A written value reads back on the cycle after the write.
- R3: With the prescaler off and the channel enabled, pulses come every D+1 reference ticks. The first comes on the (D+1)-th tick after the enabling write.
- R4: A pulse is high for exactly one clock and follows only a clock edge at which the reference tick input was high.
- R5: The square-wave output flips on every pulse and nowhere else while enabled.
- R6: With bit 0 set, only every 16th reference tick reaches the counter, so the period is 16*(D+1) reference ticks.
- R7: While bit 16 is clear the outputs stay 0 and divisor writes cause no pulse. A later enable starts a full period.
- R8: A divisor written while running does not cut the period in progress; it applies from the next reload.
- R9: D = 0 gives a pulse on every reference tick.
- R10: D = 4095, the largest value, gives a period of 4096 reference ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference tick enable, one clock wide |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 17 | Configuration write data |
| cfg_rdata_o | output | 17 | Configuration read-back |
| baud_pulse_o | output | 1 | Bit-rate clock-enable pulse |
| baud_toggle_o | output | 1 | Square wave, flips on each pulse |

## Verification
A write lands at the clock edge where its strobe is sampled, and the read-back shows it from that edge on. A pulse is registered, so it appears on the edge that consumes the terminal reference tick: edge w + D + 1 for a write at edge w with ticks every cycle. The square wave changes on that same edge. The driver turns each write's edge number and the tick pattern into the list of edge numbers at which pulses are due. The monitor samples at the falling edge and compares each pulse with the head of that list. Any pulse that finds the list empty counts as a failure.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int unsigned CFG_W         = 17;
  localparam int unsigned EN_POS        = 16;
  localparam int unsigned PRE_POS       = 0;
  localparam int unsigned DIV_LSB       = 1;
  localparam int unsigned DIV_W_DEF     = 12;
  localparam int unsigned PRE_RATIO_DEF = 16;

  // writable bits of the configuration word
  function automatic logic [CFG_W-1:0] cfg_mask(int unsigned div_w);
    logic [CFG_W-1:0] m;
    m = '0;
    m[EN_POS]  = 1'b1;
    m[PRE_POS] = 1'b1;
    for (int unsigned i = 0; i < div_w; i++) m[DIV_LSB+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baud_gen_pkg::*;
#(
  parameter int unsigned DIV_W = DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             en_o,
  output logic             pre_o,
  output logic [DIV_W-1:0] div_o,
  output logic [DIV_W-1:0] div_nxt_o
);
  localparam logic [CFG_W-1:0] MASK = cfg_mask(DIV_W);

  logic [CFG_W-1:0] cfg_q, cfg_nxt;

  assign cfg_nxt = we_i ? (wdata_i & MASK) : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_nxt;
  end

  assign cfg_o     = cfg_q;
  assign en_o      = cfg_q[EN_POS];
  assign pre_o     = cfg_q[PRE_POS];
  assign div_o     = cfg_q[DIV_LSB +: DIV_W];
  // seen by a stopped counter so a start-and-load write is one step
  assign div_nxt_o = cfg_nxt[DIV_LSB +: DIV_W];
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned PRE_RATIO = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pre_on_i,
  input  logic ref_tick_i,
  output logic tick_o
);
  localparam int unsigned CW = (PRE_RATIO > 2) ? $clog2(PRE_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRE_RATIO - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!en_i)                 cnt_q <= '0;
    else if (pre_on_i && ref_tick_i) cnt_q <= at_last ? '0 : cnt_q + CW'(1);
  end

  assign tick_o = ref_tick_i && (!pre_on_i || at_last);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] reload_i,
  input  logic [DIV_W-1:0] hold_i,
  output logic             pulse_o,
  output logic             toggle_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             pulse_q, tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      tog_q   <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= hold_i;
      pulse_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (tick_i) begin
        if (cnt_q == '0) begin
          cnt_q   <= reload_i;
          pulse_q <= 1'b1;
          tog_q   <= ~tog_q;
        end else begin
          cnt_q <= cnt_q - DIV_W'(1);
        end
      end
    end
  end

  assign pulse_o  = pulse_q;
  assign toggle_o = tog_q;
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int unsigned DIV_W     = DIV_W_DEF,
  parameter int unsigned PRE_RATIO = PRE_RATIO_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             baud_pulse_o,
  output logic             baud_toggle_o
);
  logic             en, pre_on, tick;
  logic [DIV_W-1:0] div_q, div_nxt;

  baud_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .cfg_o     (cfg_rdata_o),
    .en_o      (en),
    .pre_o     (pre_on),
    .div_o     (div_q),
    .div_nxt_o (div_nxt)
  );

  baud_prescaler #(.PRE_RATIO(PRE_RATIO)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .pre_on_i   (pre_on),
    .ref_tick_i (ref_tick_i),
    .tick_o     (tick)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .tick_i   (tick),
    .reload_i (div_q),
    .hold_i   (div_nxt),
    .pulse_o  (baud_pulse_o),
    .toggle_o (baud_toggle_o)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk
  import baud_gen_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_tick_i,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_wdata_i,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic             baud_pulse_o,
  input logic             baud_toggle_o
);
  localparam logic [CFG_W-1:0] MASK = cfg_mask(DIV_W_DEF);

  AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o == ($past(cfg_wdata_i) & MASK)); // R2

  AST_PULSE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_pulse_o |-> $past(ref_tick_i)); // R4

  AST_TOGGLE_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[EN_POS] && $past(cfg_rdata_o[EN_POS]))
      |-> (baud_pulse_o == (baud_toggle_o != $past(baud_toggle_o)))); // R5

  AST_PRESCALED_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[PRE_POS] && cfg_rdata_o[EN_POS] && baud_pulse_o) |=> !baud_pulse_o); // R6

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rdata_o[EN_POS] |=> (!baud_pulse_o && !baud_toggle_o)); // R7
endmodule

bind baud_gen baud_gen_chk u_chk (.*);

// File: tb/tb_baud_gen.sv
module tb_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        we = 1'b0;
  logic [16:0] wdata = '0;
  logic [16:0] rdata;
  logic        pulse, toggle;

  always #4 clk = ~clk;

  baud_gen dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ref_tick_i    (ref_tick),
    .cfg_we_i      (we),
    .cfg_wdata_i   (wdata),
    .cfg_rdata_o   (rdata),
    .baud_pulse_o  (pulse),
    .baud_toggle_o (toggle)
  );

  int    cyc = 0;
  int    exp_q[$];
  int    n_chk = 0, n_fail = 0;
  int    ref_mod = 1;
  int    next_pulse = -1;
  int    last_exp = 0;
  bit    exp_tog = 1'b0;
  bit    done = 1'b0;
  string tag = "R3";

  always @(posedge clk) cyc <= cyc + 1;

  // reference tick for edge cyc+1
  always @(negedge clk) ref_tick = ((cyc + 1) % ref_mod == 0);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // called at a falling edge; write lands at edge w
  task automatic cfg_write(input logic [16:0] v, output int w);
    we = 1'b1;
    wdata = v;
    w = cyc + 1;
    if (next_pulse == w) exp_q.push_back(w);
    next_pulse = -1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // expected pulse edges after an enabling write at edge w
  task automatic plan(input int w, input int d, input bit pre, input int n);
    int e = w, rc = 0, eff = 0, k = 0;
    while (k <= n) begin
      e++;
      if (e % ref_mod == 0) begin
        rc++;
        if (!pre || (rc % 16 == 0)) begin
          eff++;
          if (eff % (d + 1) == 0) begin
            if (k < n) begin exp_q.push_back(e); last_exp = e; end
            else next_pulse = e;
            k++;
          end
        end
      end
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic start(input int d, input bit pre, input int n, output int w);
    cfg_write({1'b1, 3'b000, d[11:0], pre}, w);
    plan(w, d, pre, n);
  endtask

  task automatic stop();
    int w;
    cfg_write(17'h0, w);
    @(negedge clk);
    exp_tog = 1'b0;
    check(pulse == 1'b0 && toggle == 1'b0, "R7 idle after stop", {pulse, toggle}, 0);
    check(exp_q.size() == 0, {tag, " all pulses seen"}, exp_q.size(), 0);
  endtask

  // monitor: scoreboard pops
  always @(negedge clk) begin
    if (rst_n && pulse) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected pulse", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(e == cyc, {tag, " pulse cycle"}, cyc, e);
        exp_tog = ~exp_tog;
        check(toggle == exp_tog, "R5 toggle follows pulse", toggle, exp_tog);
      end
    end
    if (!done && cyc > 150000) begin
      done = 1'b1;
      check(1'b0, "watchdog", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    check(pulse == 1'b0 && toggle == 1'b0, "R1 outputs at reset", {pulse, toggle}, 0);
    check(rdata == 17'h0, "R1 config at reset", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 masking and read-back, channel stopped
    cfg_write(17'h0FFFF, w);
    check(rdata == 17'h01FFF, "R2 read-back masks bits 15:13", rdata, 17'h01FFF);
    cfg_write(17'h0000A, w);
    check(rdata == 17'h0000A, "R2 read-back divisor", rdata, 17'h0000A);
    repeat (30) @(negedge clk);
    check(pulse == 1'b0 && toggle == 1'b0, "R7 no pulse while stopped", {pulse, toggle}, 0);

    // R3 basic period
    tag = "R3";
    start(3, 1'b0, 5, w);
    wait_until(last_exp);
    stop();

    // R7 restart gives a full first period
    tag = "R7";
    start(3, 1'b0, 2, w);
    wait_until(last_exp);
    stop();

    // R9 every tick
    tag = "R9";
    start(0, 1'b0, 6, w);
    wait_until(last_exp);
    stop();

    // R6 prescaler
    tag = "R6";
    start(1, 1'b1, 3, w);
    wait_until(last_exp);
    stop();

    // R4 sparse reference ticks
    tag = "R4";
    ref_mod = 3;
    @(negedge clk);
    start(2, 1'b0, 4, w);
    wait_until(last_exp);
    stop();
    ref_mod = 5;
    @(negedge clk);
    start(1, 1'b1, 2, w);
    wait_until(last_exp);
    stop();
    ref_mod = 1;
    @(negedge clk);

    // R8 divisor change mid-period
    tag = "R8";
    begin
      int w0, w2, p;
      start(5, 1'b0, 2, w0);
      wait_until(last_exp + 2);
      p = w0 + 18;
      cfg_write({1'b1, 3'b000, 12'd2, 1'b0}, w2);
      check(w2 < p, "R8 write before terminal", w2, p);
      exp_q.push_back(p);
      exp_q.push_back(p + 3);
      exp_q.push_back(p + 6);
      last_exp = p + 6;
      next_pulse = p + 9;
      wait_until(last_exp);
      stop();
    end

    // R10 largest divisor
    tag = "R10";
    start(4095, 1'b0, 1, w);
    wait_until(last_exp);
    stop();

    repeat (20) @(negedge clk);
    check(pulse == 1'b0 && toggle == 1'b0, "R7 quiet at end", {pulse, toggle}, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule